// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Processor Sequencer

This block is the control core of a small 8-bit processor. It holds four 8-bit general registers, a 16-bit program counter, a 16-bit stack pointer, four condition flags (zero, negative, carry, overflow) and a halt state. It drives a byte-wide memory with a 16-bit address through a read strobe and a write strobe. A read returns its byte one cycle after the strobe, and the sequencer spends a wait state before it captures that byte.

Each instruction is 16 bits, fetched as two bytes with the high byte first. The top nibble selects the operation, bits 11:10 select the destination register `rd` and bits 9:8 select the source register `rs`. The low byte is fetched but not used by any operation here. Memory and control-flow operations are followed by a 16-bit big-endian absolute address. Arithmetic and logic go through an instantiated combinational ALU. A one-cycle `retired` pulse marks each completed instruction, and `halted` reports the stopped state, so the surrounding system can count the instructions that ran.

Top module: `byte_seq_cpu`

## Requirements
- R1: After reset, PC=0x0000, SP=0x0000, all flags are 0, all registers are 0 and the block is not halted. The first cycle after reset drives a read of address 0x0000.
- R2: A read is a single-cycle `mem_rd` strobe, and the data is taken from `mem_rdata` in the following cycle. No read strobe is ever driven in two consecutive cycles. The instruction is the byte at PC (bits 15:8) followed by the byte at PC+1 (bits 7:0). PC then advances by 2, wrapping from 0xFFFF to 0x0000. Decode: opcode = bits 15:12, rd = bits 11:10, rs = bits 9:8.
- R3: Opcodes 0xA to 0xE read a further 16-bit address, high byte first, from the next two bytes, and PC advances by 2 more. No other opcode reads address bytes.
- R4: Opcodes 0x0 to 0x8 write rd := f(rd, rs), where f is: 0x0 add, 0x1 subtract, 0x2 AND, 0x3 OR, 0x4 XOR, 0x5 shift left by 1, 0x6 logical shift right by 1, 0x7 low byte of the product, 0x8 unsigned quotient. A quotient with a zero divisor gives 0x00.
- R5: Flags change only for opcodes 0x0 to 0xA. Z = result is 0x00 and N = bit 7 of the result. For LOAD, Z and N come from the loaded byte, and C and V are cleared. STORE, JMP, JZ, CALL and HALT leave every flag unchanged.
- R6: Opcode 0x9 (compare) sets the flags of rd minus rs and leaves rd unchanged.
- R7: Opcode 0xA (LOAD) writes mem[addr] into rd. Opcode 0xB (STORE) writes register rs to mem[addr] with one `mem_wr` strobe and changes no register.
- R8: Opcode 0xC loads PC with addr. Opcode 0xD loads PC with addr when Z=1, and otherwise continues at the instruction after the address bytes.
- R9: Opcode 0xE writes the return address (the byte after the address bytes) to the stack: the high byte at SP-1, then the low byte at SP-2. SP ends two lower, wrapping at 16 bits, and PC is then loaded with addr.
- R10: Opcode 0xF halts the block. While halted, `halted`=1, no strobe of any kind is driven, `retired` stays 0, and PC and SP hold.
- R11: `retired` pulses for exactly one cycle per completed instruction, HALT included.
- R12: `mem_rd` and `mem_wr` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Write data |
| halted | output | 1 | High once the halt opcode has run |
| retired | output | 1 | One-cycle pulse per completed instruction |

## Verification
Registers and flags have no port of their own. A wrong register value first shows as a wrong byte on `mem_wdata` at the next STORE, and a wrong Z flag shows as the wrong next fetch address after the following JZ. The programs therefore store every result and branch on every flag setting they need to observe.

A wrong PC or wrong operand-byte count shows on `mem_addr` within a few cycles, and then as a missing halt or a wrong `retired` count. A stack fault shows directly as the address and data of the two push writes. Because of this, each test ends with HALT and checks the stored bytes, the retirement count, and the absence of any memory traffic after the halt.

// File: rtl/seq_alu.sv
module seq_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         vf
);
  logic [W:0]     s;
  logic [2*W-1:0] p;

  always_comb begin
    res = a;
    cf  = 1'b0;
    vf  = 1'b0;
    s   = '0;
    p   = '0;
    case (op)
      4'h0: begin
        s   = {1'b0, a} + {1'b0, b};
        res = s[W-1:0];
        cf  = s[W];
        vf  = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
      end
      4'h1, 4'h9: begin
        s   = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        res = s[W-1:0];
        cf  = s[W];
        vf  = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
      end
      4'h2: res = a & b;
      4'h3: res = a | b;
      4'h4: res = a ^ b;
      4'h5: begin
        res = {a[W-2:0], 1'b0};
        cf  = a[W-1];
      end
      4'h6: begin
        res = {1'b0, a[W-1:1]};
        cf  = a[0];
      end
      4'h7: begin
        p   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        res = p[W-1:0];
        cf  = |p[2*W-1:W];
      end
      4'h8: begin
        if (b == '0) begin
          res = '0;
          cf  = 1'b1;
          vf  = 1'b1;
        end else begin
          res = a / b;
        end
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/byte_seq_cpu.sv
module byte_seq_cpu #(
  parameter int DW   = 8,
  parameter int AW   = 16,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          halted,
  output logic          retired
);
  localparam int RW = $clog2(NREG);

  typedef enum logic [3:0] {
    S_IHI_RQ, S_IHI_CP, S_ILO_RQ, S_ILO_CP,
    S_AHI_RQ, S_AHI_CP, S_ALO_RQ, S_ALO_CP,
    S_EXEC, S_LD_RQ, S_LD_CP, S_PSH_HI, S_PSH_LO, S_HALT
  } state_t;

  state_t        state;
  logic [DW-1:0] gpr [NREG];
  logic [AW-1:0] pc, sp, tgt;
  logic [DW-1:0] ir;
  logic          fz, fn, fc, fv;

  logic [3:0]    opc;
  logic [RW-1:0] rd, rs;
  logic          wide;
  logic [DW-1:0] alu_res;
  logic          alu_c, alu_v;

  assign opc  = ir[DW-1:DW-4];
  assign rd   = ir[DW-5:DW-4-RW];
  assign rs   = ir[DW-5-RW:DW-4-2*RW];
  assign wide = (opc >= 4'hA) && (opc <= 4'hE);

  seq_alu #(.W(DW)) alu_i (
    .op (opc),
    .a  (gpr[rd]),
    .b  (gpr[rs]),
    .res(alu_res),
    .cf (alu_c),
    .vf (alu_v)
  );

  assign mem_rd = (state == S_IHI_RQ) || (state == S_ILO_RQ) ||
                  (state == S_AHI_RQ) || (state == S_ALO_RQ) || (state == S_LD_RQ);
  assign mem_wr = ((state == S_EXEC) && (opc == 4'hB)) ||
                  (state == S_PSH_HI) || (state == S_PSH_LO);
  assign halted = (state == S_HALT);
  assign retired = ((state == S_EXEC) && (opc != 4'hA) && (opc != 4'hE)) ||
                   (state == S_LD_CP) || (state == S_PSH_LO);

  always_comb begin
    case (state)
      S_EXEC, S_LD_RQ:    mem_addr = tgt;
      S_PSH_HI, S_PSH_LO: mem_addr = sp - AW'(1);
      default:            mem_addr = pc;
    endcase
    case (state)
      S_PSH_HI: mem_wdata = pc[AW-1:AW-DW];
      S_PSH_LO: mem_wdata = pc[DW-1:0];
      default:  mem_wdata = gpr[rs];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IHI_RQ;
      pc    <= '0;
      sp    <= '0;
      tgt   <= '0;
      ir    <= '0;
      fz    <= 1'b0;
      fn    <= 1'b0;
      fc    <= 1'b0;
      fv    <= 1'b0;
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else begin
      case (state)
        S_IHI_RQ: state <= S_IHI_CP;
        S_IHI_CP: begin
          ir    <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_ILO_RQ;
        end
        S_ILO_RQ: state <= S_ILO_CP;
        S_ILO_CP: begin
          pc    <= pc + AW'(1);
          state <= wide ? S_AHI_RQ : S_EXEC;
        end
        S_AHI_RQ: state <= S_AHI_CP;
        S_AHI_CP: begin
          tgt[AW-1:AW-DW] <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_ALO_RQ;
        end
        S_ALO_RQ: state <= S_ALO_CP;
        S_ALO_CP: begin
          tgt[DW-1:0] <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_IHI_RQ;
          case (opc)
            4'hA: state <= S_LD_RQ;
            4'hB: ;
            4'hC: pc <= tgt;
            4'hD: if (fz) pc <= tgt;
            4'hE: state <= S_PSH_HI;
            4'hF: state <= S_HALT;
            default: begin
              fz <= (alu_res == '0);
              fn <= alu_res[DW-1];
              fc <= alu_c;
              fv <= alu_v;
              if (opc != 4'h9) gpr[rd] <= alu_res;
            end
          endcase
        end
        S_LD_RQ: state <= S_LD_CP;
        S_LD_CP: begin
          gpr[rd] <= mem_rdata;
          fz    <= (mem_rdata == '0);
          fn    <= mem_rdata[DW-1];
          fc    <= 1'b0;
          fv    <= 1'b0;
          state <= S_IHI_RQ;
        end
        S_PSH_HI: begin
          sp    <= sp - AW'(1);
          state <= S_PSH_LO;
        end
        S_PSH_LO: begin
          sp    <= sp - AW'(1);
          pc    <= tgt;
          state <= S_IHI_RQ;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R12
  AST_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr && !retired)); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(sp))); // R10
  AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    retired |=> !retired); // R11
  AST_RETIRE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    retired |=> (halted || (mem_rd && mem_addr == pc))); // R11
  AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && (state != S_EXEC)) |=> (sp == $past(sp) - AW'(1))); // R9
  AST_SP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |=> $stable(sp)); // R9
endmodule

// File: tb/byte_seq_cpu_tb_top.sv
`timescale 1ns/1ps
module byte_seq_cpu_tb_top;
  localparam int MEMN = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, halted, retired;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;

  logic [7:0]  mem [MEMN];
  logic        clr = 1'b0, ld_en = 1'b0;
  logic [10:0] ld_a = '0;
  logic [7:0]  ld_d = '0;
  int          rcount, post_halt;
  logic [15:0] w0, w1, w2, last_rd;
  logic        wrapped;
  logic [15:0] wp;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  byte_seq_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .halted(halted), .retired(retired)
  );

  always @(posedge clk) begin
    if (clr) for (int i = 0; i < MEMN; i++) mem[i] <= 8'h00;
    else if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_wr) mem[mem_addr[10:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[10:0]];
    if (!rst_n) begin
      rcount <= 0; post_halt <= 0; wrapped <= 1'b0;
      w0 <= '0; w1 <= '0; w2 <= '0; last_rd <= '0;
    end else begin
      if (retired) rcount <= rcount + 1;
      if (halted && (mem_rd || mem_wr)) post_halt <= post_halt + 1;
      if (mem_wr) begin w0 <= mem_addr; w1 <= w0; w2 <= w1; end
      if (mem_rd) begin
        if (mem_addr == 16'h0000 && last_rd == 16'hFFFF) wrapped <= 1'b1;
        last_rd <= mem_addr;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a[10:0]; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic emit(input logic [15:0] w);
    poke(wp, w[15:8]);
    poke(wp + 16'd1, w[7:0]);
    wp = wp + 16'd2;
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [1:0] d, input logic [1:0] s);
    return {op, d, s, 8'h00};
  endfunction

  task automatic emita(input logic [3:0] op, input logic [1:0] d, input logic [1:0] s, input logic [15:0] a);
    emit(ins(op, d, s));
    emit(a);
  endtask

  task automatic prep();
    @(negedge clk);
    rst_n = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    wp = 16'h0000;
  endtask

  task automatic go(input int maxcyc);
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < maxcyc) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      total++; bad++;
      $display("FAIL run watchdog: actual=running expected=halted");
    end
  endtask

  function automatic int peek(input logic [15:0] a);
    return int'(mem[a[10:0]]);
  endfunction

  task automatic t_reset();
    prep();
    poke(16'h0440, 8'hEE);
    emita(4'hD, 0, 0, 16'h0010);
    emita(4'hB, 0, 0, 16'h0440);
    emit(ins(4'hF, 0, 0));
    wp = 16'h0010;
    emit(ins(4'hF, 0, 0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 first read strobe", int'(mem_rd), 1);
    check("R1 first read address", int'(mem_addr), 0);
    check("R1 not halted", int'(halted), 0);
    check("R1 no retire", int'(retired), 0);
    rst_n = 1'b0;
    go(500);
    check("R1 reset Z=0 so JZ falls through, r0=0 stored", peek(16'h0440), 8'h00);
    check("R11 retired count reset", rcount, 3);
  endtask

  task automatic t_alu();
    prep();
    poke(16'h0400, 8'h70); poke(16'h0401, 8'h30); poke(16'h0402, 8'h0F);
    emita(4'hA, 0, 0, 16'h0400);
    emita(4'hA, 1, 0, 16'h0401);
    emita(4'hA, 2, 0, 16'h0402);
    emit(ins(4'h0, 0, 1));
    emit(ins(4'h1, 1, 2));
    emita(4'hB, 0, 0, 16'h0410);
    emita(4'hB, 0, 1, 16'h0411);
    emit(ins(4'h3, 2, 1));
    emit(ins(4'h4, 1, 2));
    emita(4'hB, 0, 2, 16'h0412);
    emita(4'hB, 0, 1, 16'h0413);
    emit(ins(4'h5, 0, 0));
    emit(ins(4'h6, 2, 0));
    emit(ins(4'h2, 1, 2));
    emita(4'hB, 0, 0, 16'h0414);
    emita(4'hB, 0, 2, 16'h0415);
    emita(4'hB, 0, 1, 16'h0416);
    emit(ins(4'hF, 0, 0));
    go(2000);
    check("R4 add", peek(16'h0410), 8'hA0);
    check("R4 sub", peek(16'h0411), 8'h21);
    check("R4 or", peek(16'h0412), 8'h2F);
    check("R4 xor", peek(16'h0413), 8'h0E);
    check("R4 shl", peek(16'h0414), 8'h40);
    check("R4 shr", peek(16'h0415), 8'h17);
    check("R4 and", peek(16'h0416), 8'h06);
    check("R11 retired count alu", rcount, 18);
  endtask

  task automatic t_muldiv();
    logic [15:0] skip;
    prep();
    poke(16'h0400, 8'h14); poke(16'h0401, 8'h0D);
    emita(4'hA, 0, 0, 16'h0400);
    emita(4'hA, 1, 0, 16'h0401);
    emita(4'hA, 3, 0, 16'h0400);
    emit(ins(4'h7, 0, 1));
    emit(ins(4'h8, 3, 1));
    emit(ins(4'h8, 1, 2));
    emita(4'hB, 0, 0, 16'h0410);
    emita(4'hB, 0, 3, 16'h0411);
    emita(4'hB, 0, 1, 16'h0412);
    skip = wp + 16'd8;
    emita(4'hD, 0, 0, skip);
    emita(4'hB, 0, 0, 16'h0413);
    emit(ins(4'hF, 0, 0));
    go(2000);
    check("R4 mul low byte", peek(16'h0410), 8'h04);
    check("R4 div", peek(16'h0411), 8'h01);
    check("R4 div by zero gives 0", peek(16'h0412), 8'h00);
    check("R5 Z kept across STORE, JZ taken", peek(16'h0413), 8'h00);
  endtask

  task automatic t_flags();
    logic [15:0] l1, l2, l3, l4;
    prep();
    poke(16'h0400, 8'h5A); poke(16'h0401, 8'h5A); poke(16'h0402, 8'h01);
    emita(4'hA, 0, 0, 16'h0400);
    emita(4'hA, 1, 0, 16'h0401);
    emit(ins(4'h9, 0, 1));
    l1 = wp + 16'd8;
    emita(4'hD, 0, 0, l1);
    emita(4'hB, 0, 0, 16'h0420);
    emita(4'hB, 0, 0, 16'h0421);
    emita(4'hA, 2, 0, 16'h0402);
    l2 = wp + 16'd8;
    emita(4'hD, 0, 0, l2);
    emita(4'hB, 0, 2, 16'h0422);
    l3 = wp + 16'd8;
    emita(4'hC, 0, 0, l3);
    emita(4'hB, 0, 2, 16'h0423);
    emita(4'hA, 3, 0, 16'h0403);
    l4 = wp + 16'd8;
    emita(4'hD, 0, 0, l4);
    emita(4'hB, 0, 2, 16'h0424);
    emit(ins(4'hF, 0, 0));
    go(2000);
    check("R6 compare equal sets Z, JZ taken", peek(16'h0420), 8'h00);
    check("R6 compare leaves rd", peek(16'h0421), 8'h5A);
    check("R8 JZ not taken after nonzero LOAD (R5)", peek(16'h0422), 8'h01);
    check("R8 JMP skips", peek(16'h0423), 8'h00);
    check("R5 LOAD of zero sets Z", peek(16'h0424), 8'h00);
    check("R11 retired count flags", rcount, 12);
  endtask

  task automatic t_call();
    prep();
    poke(16'h0400, 8'h33);
    emita(4'hC, 0, 0, 16'h0120);
    wp = 16'h0120;
    emita(4'hA, 0, 0, 16'h0400);
    emita(4'hE, 0, 0, 16'h0200);
    emita(4'hB, 0, 0, 16'h0430);
    wp = 16'h0200;
    emita(4'hB, 0, 0, 16'h0431);
    emit(ins(4'hF, 0, 0));
    go(2000);
    check("R9 push high at SP-1 wraps", int'(w2), 16'hFFFF);
    check("R9 push low at SP-2", int'(w1), 16'hFFFE);
    check("R9 return high byte", peek(16'hFFFF), 8'h01);
    check("R9 return low byte", peek(16'hFFFE), 8'h28);
    check("R7 STORE at target", int'(w0), 16'h0431);
    check("R7 LOAD then STORE value", peek(16'h0431), 8'h33);
    check("R9 jumped, no fall-through", peek(16'h0430), 8'h00);
  endtask

  task automatic t_wrap();
    prep();
    emita(4'hD, 0, 0, 16'h0020);
    emita(4'hC, 0, 0, 16'hFFFE);
    wp = 16'h0020;
    emit(ins(4'hF, 0, 0));
    wp = 16'hFFFE;
    emit(ins(4'h0, 0, 0));
    go(2000);
    check("R2 PC wraps FFFF to 0000", int'(wrapped), 1);
    check("R3 R8 path retired count", rcount, 5);
  endtask

  task automatic t_halt();
    prep();
    emit(ins(4'hF, 0, 0));
    poke(16'h0002, 8'hB0);
    go(500);
    repeat (40) @(negedge clk);
    check("R10 stays halted", int'(halted), 1);
    check("R10 no strobes after halt", post_halt, 0);
    check("R11 halt retires once", rcount, 1);
    check("R3 HALT reads no address bytes", int'(last_rd), 16'h0001);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_muldiv();
    t_flags();
    t_call();
    t_wrap();
    t_halt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule